// File: doc/BRIEF.md
# Shift-Type Decoder and 32-bit Barrel Shifter

This block turns a shift request into a 32-bit result and a shifter carry-out. A request has one of three forms. The first is a packed immediate: a 2-bit kind and a 5-bit count. Here a zero count is reused to mean a shift of 32, or a rotate through carry by one. The second is a register form: the same 2-bit kind with an 8-bit count taken literally. The third is a direct form: a 3-bit operation code with the 8-bit count.

The block decodes the request into a left shift, a logical right shift, an arithmetic right shift, a rotate, or a rotate through carry. A barrel core then computes the result and the carry-out. When the final count is zero, the core passes the operand and the carry-in through unchanged. Illegal requests raise an error flag and force the result and the carry to zero. An optional output register stage, on by default, adds one cycle of latency.

Top module: `shf_unit`

## Requirements
- R1: Immediate mode (`req_mode`=0) with `shift_kind`=0 is a left shift by `imm_cnt` exactly as given; a count of 0 passes the operand and carry-in through.
- R2: Immediate mode with `shift_kind`=1 is a logical right shift and with `shift_kind`=2 an arithmetic right shift; an `imm_cnt` of 0 means a shift of 32.
- R3: Immediate mode with `shift_kind`=3 is a rotate by `imm_cnt` when it is nonzero, and a rotate through carry by one when it is 0.
- R4: For left, right and rotate operations with a final count of 0, `result` equals `operand` and `carry_out` equals `carry_in`.
- R5: A left shift by n (1..32) gives carry `operand[32-n]`; for n greater than 32 the result and carry are both 0.
- R6: A logical right shift by n (1..32) gives carry `operand[n-1]`; for n greater than 32 the result and carry are both 0.
- R7: An arithmetic right shift by n fills from `operand[31]` with carry `operand[n-1]`; for n of 32 or more the result is all copies of bit 31 and the carry equals bit 31.
- R8: A rotate by a nonzero n turns right by n modulo 32, and the carry is bit 31 of the rotated result.
- R9: A rotate through carry gives `{carry_in, operand[31:1]}` with carry `operand[0]`.
- R10: Register mode (`req_mode`=1) maps `shift_kind` 0,1,2,3 to left, logical right, arithmetic right and rotate, with `reg_cnt` used literally.
- R11: Direct mode (`req_mode`=2) takes `direct_op` 0..4 as left, logical right, arithmetic right, rotate and rotate through carry, with count `reg_cnt`. A rotate through carry with a count other than 1, or a code from 5 to 7, sets `error` and forces `result` and `carry_out` to 0.
- R12: `req_mode`=3 is reserved: it sets `error` with a zero result and carry.
- R13: With the output stage enabled, the outputs follow the inputs one clock edge later, and a synchronous reset clears `result`, `carry_out` and `error` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_mode | input | 2 | 0 immediate, 1 register, 2 direct, 3 reserved |
| shift_kind | input | 2 | Shift kind for immediate and register modes |
| imm_cnt | input | 5 | Packed immediate count |
| reg_cnt | input | 8 | Literal count for register and direct modes |
| direct_op | input | 3 | Operation code for direct mode |
| operand | input | 32 | Value to shift |
| carry_in | input | 1 | Incoming carry |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Shifter carry-out |
| error | output | 1 | Illegal request flag |

## Verification
The bench targets the count boundaries at 0, 1, 31, 32, 33 and 255. An off-by-one in the clamp would show up at these counts as a stale carry bit, or as a non-zero result after a shift past the width. Zero immediates for kinds 1, 2 and 3 are driven directly. A decoder that took the zero literally would return the operand unshifted, and would rotate where it should bring the carry in at the top. Rotates by multiples of 32 check that the carry is the rotated top bit and not the carry-in. Rotate-through-carry requests with counts 0 and 2, and the unused operation codes, check that the error path clears both the result and the carry.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ROR = 3'd3,
    OP_RRX = 3'd4,
    OP_BAD = 3'd5
  } shf_op_e;

  localparam logic [1:0] MODE_IMM = 2'd0;
  localparam logic [1:0] MODE_REG = 2'd1;
  localparam logic [1:0] MODE_DIR = 2'd2;
endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(W)
) (
  input  logic [1:0]       req_mode,
  input  logic [1:0]       shift_kind,
  input  logic [LOG_W-1:0] imm_cnt,
  input  logic [AMT_W-1:0] reg_cnt,
  input  logic [2:0]       direct_op,
  output shf_op_e          dec_op,
  output logic [AMT_W-1:0] dec_amt
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  logic             imm_zero;
  logic [AMT_W-1:0] imm_ext;

  assign imm_zero = (imm_cnt == '0);
  assign imm_ext  = AMT_W'(imm_cnt);

  always_comb begin
    dec_op  = OP_BAD;
    dec_amt = '0;
    unique case (req_mode)
      MODE_IMM: begin
        unique case (shift_kind)
          2'd0: begin dec_op = OP_LSL; dec_amt = imm_ext; end
          2'd1: begin dec_op = OP_LSR; dec_amt = imm_zero ? FULL : imm_ext; end
          2'd2: begin dec_op = OP_ASR; dec_amt = imm_zero ? FULL : imm_ext; end
          default: begin
            dec_op  = imm_zero ? OP_RRX : OP_ROR;
            dec_amt = imm_zero ? AMT_W'(1) : imm_ext;
          end
        endcase
      end
      MODE_REG: begin
        dec_op  = shf_op_e'({1'b0, shift_kind});
        dec_amt = reg_cnt;
      end
      MODE_DIR: begin
        dec_op  = (direct_op > 3'd4) ? OP_BAD : shf_op_e'(direct_op);
        dec_amt = reg_cnt;
      end
      default: begin
        dec_op  = OP_BAD;
        dec_amt = '0;
      end
    endcase
  end
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(W),
  localparam int SH_W  = LOG_W + 1
) (
  input  shf_op_e          op,
  input  logic [AMT_W-1:0] amt,
  input  logic [W-1:0]     opnd,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout,
  output logic             err
);
  localparam logic [AMT_W-1:0] W_A = AMT_W'(W);
  localparam logic [SH_W-1:0]  W_S = SH_W'(W);

  logic                  over;
  logic [SH_W-1:0]       amt_lim;
  logic [LOG_W-1:0]      rot_m;
  logic [2*W-1:0]        wide_l;
  logic [2*W-1:0]        wide_r;
  logic signed [2*W-1:0] wide_a;
  logic [W-1:0]          rot;

  // clamp the count to the word width so every shifter stays 2W bits wide
  assign over    = (amt > W_A);
  assign amt_lim = over ? W_S : amt[SH_W-1:0];
  assign rot_m   = amt[LOG_W-1:0];

  assign wide_l = {{W{1'b0}}, opnd} << amt_lim;
  assign wide_r = {opnd, {W{1'b0}}} >> amt_lim;
  assign wide_a = $signed({opnd, {W{1'b0}}}) >>> amt_lim;
  assign rot    = (opnd >> rot_m) | (opnd << (W_S - {1'b0, rot_m}));

  always_comb begin
    res  = '0;
    cout = 1'b0;
    err  = 1'b0;
    if (op == OP_BAD || (op == OP_RRX && amt != AMT_W'(1))) begin
      err = 1'b1;
    end else if (op != OP_RRX && amt == '0) begin
      res  = opnd;
      cout = cin;
    end else begin
      unique case (op)
        OP_LSL: begin
          res  = over ? '0 : wide_l[W-1:0];
          cout = over ? 1'b0 : wide_l[W];
        end
        OP_LSR: begin
          res  = over ? '0 : wide_r[2*W-1:W];
          cout = over ? 1'b0 : wide_r[W-1];
        end
        OP_ASR: begin
          res  = wide_a[2*W-1:W];
          cout = wide_a[W-1];
        end
        OP_ROR: begin
          res  = rot;
          cout = rot[W-1];
        end
        default: begin
          res  = {cin, opnd[W-1:1]};
          cout = opnd[0];
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int LOG_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       req_mode,
  input  logic [1:0]       shift_kind,
  input  logic [LOG_W-1:0] imm_cnt,
  input  logic [AMT_W-1:0] reg_cnt,
  input  logic [2:0]       direct_op,
  input  logic [W-1:0]     operand,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             carry_out,
  output logic             error
);
  shf_op_e          dec_op;
  logic [AMT_W-1:0] dec_amt;
  logic [W-1:0]     core_res;
  logic             core_cout;
  logic             core_err;

  shf_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
    .req_mode  (req_mode),
    .shift_kind(shift_kind),
    .imm_cnt   (imm_cnt),
    .reg_cnt   (reg_cnt),
    .direct_op (direct_op),
    .dec_op    (dec_op),
    .dec_amt   (dec_amt)
  );

  shf_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .op  (dec_op),
    .amt (dec_amt),
    .opnd(operand),
    .cin (carry_in),
    .res (core_res),
    .cout(core_cout),
    .err (core_err)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result    <= '0;
          carry_out <= 1'b0;
          error     <= 1'b0;
        end else begin
          result    <= core_res;
          carry_out <= core_cout;
          error     <= core_err;
        end
      end

      AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (result == $past(core_res) && error == $past(core_err))); // R13
    end else begin : g_comb
      assign result    = core_res;
      assign carry_out = core_cout;
      assign error     = core_err;
    end
  endgenerate

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    error |-> (result == '0 && !carry_out)); // R11

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (dec_amt == '0 && !core_err) |-> (core_res == operand && core_cout == carry_in)); // R4

  AST_IMM_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (req_mode == MODE_IMM && shift_kind != 2'd0) |-> (dec_amt != '0)); // R2

  AST_RRX_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (dec_op == OP_RRX && !core_err) |->
      (core_res[W-1] == carry_in && core_res[W-2:0] == operand[W-1:1] && core_cout == operand[0])); // R9

  AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (dec_op == OP_ASR && dec_amt >= AMT_W'(W)) |->
      (core_res == {W{operand[W-1]}} && core_cout == operand[W-1])); // R7

  AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (rst)
    (req_mode == 2'd3) |-> core_err); // R12
endmodule

// File: tb/tb_shf_unit.sv
module tb_shf_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  req_mode;
  logic [1:0]  shift_kind;
  logic [4:0]  imm_cnt;
  logic [7:0]  reg_cnt;
  logic [2:0]  direct_op;
  logic [31:0] operand;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;
  logic        error;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  shf_unit dut (
    .clk(clk), .rst(rst), .req_mode(req_mode), .shift_kind(shift_kind),
    .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .direct_op(direct_op),
    .operand(operand), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .error(error)
  );

  // behavioural model: one bit position per loop step
  function automatic logic [33:0] model(logic [1:0] md, logic [1:0] kd, logic [4:0] im,
                                        logic [7:0] rc, logic [2:0] dp,
                                        logic [31:0] x, logic ci);
    int op;
    int n;
    logic [31:0] v;
    logic c;
    op = 5; n = 0;
    if (md == 2'd0) begin
      if (kd == 2'd0) begin op = 0; n = int'(im); end
      else if (kd == 2'd3) begin op = (im == 0) ? 4 : 3; n = (im == 0) ? 1 : int'(im); end
      else begin op = int'(kd); n = (im == 0) ? 32 : int'(im); end
    end else if (md == 2'd1) begin
      op = int'(kd); n = int'(rc);
    end else if (md == 2'd2) begin
      op = (dp > 3'd4) ? 5 : int'(dp); n = int'(rc);
    end
    if (op == 5 || (op == 4 && n != 1)) return {1'b1, 1'b0, 32'h0};
    if (op != 4 && n == 0) return {1'b0, ci, x};
    v = x; c = ci;
    case (op)
      0: for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end
      1: for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end
      2: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
      3: begin
        for (int i = 0; i < n % 32; i++) v = {v[0], v[31:1]};
        c = v[31];
      end
      default: begin c = v[0]; v = {ci, v[31:1]}; end
    endcase
    return {1'b0, c, v};
  endfunction

  task automatic check(string tag, logic [31:0] er, logic ec, logic ee);
    n_cmp++;
    if (result !== er || carry_out !== ec || error !== ee) begin
      n_bad++;
      $display("FAIL %s: got res=%h c=%b e=%b expected res=%h c=%b e=%b",
               tag, result, carry_out, error, er, ec, ee);
    end
  endtask

  task automatic apply(logic [1:0] md, logic [1:0] kd, logic [4:0] im, logic [7:0] rc,
                       logic [2:0] dp, logic [31:0] x, logic ci);
    @(negedge clk);
    req_mode = md; shift_kind = kd; imm_cnt = im; reg_cnt = rc;
    direct_op = dp; operand = x; carry_in = ci;
    @(posedge clk);
    #1;
  endtask

  task automatic run_model(string tag, logic [1:0] md, logic [1:0] kd, logic [4:0] im,
                           logic [7:0] rc, logic [2:0] dp, logic [31:0] x, logic ci);
    logic [33:0] e;
    apply(md, kd, im, rc, dp, x, ci);
    e = model(md, kd, im, rc, dp, x, ci);
    check(tag, e[31:0], e[32], e[33]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(2'd0, 2'd0, 5'd0, 8'd0, 3'd0, 32'hFFFF_FFFF, 1'b1);
    apply(2'd0, 2'd0, 5'd0, 8'd0, 3'd0, 32'hFFFF_FFFF, 1'b1);
    check("R13 reset", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    apply(2'd1, 2'd0, 5'd0, 8'd4, 3'd0, 32'h0000_0011, 1'b0);
    check("R13 first", 32'h0000_0110, 1'b0, 1'b0);
    @(negedge clk);
    operand = 32'h0000_0022;
    #1;
    check("R13 hold before edge", 32'h0000_0110, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    check("R13 after edge", 32'h0000_0220, 1'b0, 1'b0);
  endtask

  task automatic t_directed();
    apply(2'd0, 2'd0, 5'd1, 8'd0, 3'd0, 32'h8000_0001, 1'b0);
    check("R1 lsl1", 32'h0000_0002, 1'b1, 1'b0);
    apply(2'd0, 2'd0, 5'd0, 8'd0, 3'd0, 32'h1234_5678, 1'b1);
    check("R1 lsl0 pass", 32'h1234_5678, 1'b1, 1'b0);
    apply(2'd0, 2'd1, 5'd0, 8'd0, 3'd0, 32'h8000_0000, 1'b0);
    check("R2 lsr imm0=32", 32'h0, 1'b1, 1'b0);
    apply(2'd0, 2'd2, 5'd0, 8'd0, 3'd0, 32'h8000_0000, 1'b0);
    check("R2 asr imm0=32", 32'hFFFF_FFFF, 1'b1, 1'b0);
    apply(2'd0, 2'd3, 5'd0, 8'd0, 3'd0, 32'h0000_0001, 1'b1);
    check("R3 rrx", 32'h8000_0000, 1'b1, 1'b0);
    apply(2'd0, 2'd3, 5'd8, 8'd0, 3'd0, 32'h0000_00A5, 1'b0);
    check("R3 ror8", 32'hA500_0000, 1'b1, 1'b0);
    apply(2'd1, 2'd3, 5'd0, 8'd36, 3'd0, 32'h0000_00F0, 1'b1);
    check("R8 ror36", 32'h0000_000F, 1'b0, 1'b0);
    apply(2'd1, 2'd3, 5'd0, 8'd32, 3'd0, 32'h8000_0001, 1'b0);
    check("R8 ror32", 32'h8000_0001, 1'b1, 1'b0);
    apply(2'd1, 2'd0, 5'd0, 8'd32, 3'd0, 32'h0000_0001, 1'b0);
    check("R5 lsl32", 32'h0, 1'b1, 1'b0);
    apply(2'd1, 2'd0, 5'd0, 8'd33, 3'd0, 32'hFFFF_FFFF, 1'b1);
    check("R5 lsl33", 32'h0, 1'b0, 1'b0);
    apply(2'd1, 2'd1, 5'd0, 8'd255, 3'd0, 32'hFFFF_FFFF, 1'b1);
    check("R6 lsr255", 32'h0, 1'b0, 1'b0);
    apply(2'd1, 2'd2, 5'd0, 8'd200, 3'd0, 32'h8000_0000, 1'b0);
    check("R7 asr200", 32'hFFFF_FFFF, 1'b1, 1'b0);
    apply(2'd1, 2'd1, 5'd0, 8'd0, 3'd0, 32'hCAFE_0001, 1'b1);
    check("R4 reg zero", 32'hCAFE_0001, 1'b1, 1'b0);
    apply(2'd2, 2'd0, 5'd0, 8'd1, 3'd4, 32'h0000_0003, 1'b0);
    check("R9 direct rrx", 32'h0000_0001, 1'b1, 1'b0);
    apply(2'd2, 2'd0, 5'd0, 8'd2, 3'd4, 32'hFFFF_FFFF, 1'b1);
    check("R11 rrx amt2", 32'h0, 1'b0, 1'b1);
    apply(2'd2, 2'd0, 5'd0, 8'd0, 3'd4, 32'hFFFF_FFFF, 1'b1);
    check("R11 rrx amt0", 32'h0, 1'b0, 1'b1);
    for (int c = 5; c < 8; c++) begin
      apply(2'd2, 2'd0, 5'd0, 8'd3, 3'(c), 32'hFFFF_FFFF, 1'b1);
      check("R11 bad code", 32'h0, 1'b0, 1'b1);
    end
    apply(2'd3, 2'd0, 5'd4, 8'd4, 3'd0, 32'hFFFF_FFFF, 1'b1);
    check("R12 reserved mode", 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_imm_sweep();
    logic [31:0] pats[4];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = $urandom;      pats[3] = $urandom | 32'h8000_0000;
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 4; p++)
          run_model((k == 0) ? "R1 imm sweep" : (k == 3) ? "R3 imm sweep" : "R2 imm sweep",
                    2'd0, 2'(k), 5'(a), 8'd0, 3'd0, pats[p], 1'(p));
  endtask

  task automatic t_reg_sweep();
    for (int k = 0; k < 4; k++)
      for (int a = 0; a <= 40; a++)
        for (int p = 0; p < 3; p++)
          run_model((a == 0) ? "R4 R10 reg sweep" :
                    (k == 0) ? "R5 R10 lsl" : (k == 1) ? "R6 R10 lsr" :
                    (k == 2) ? "R7 R10 asr" : "R8 R10 ror",
                    2'd1, 2'(k), 5'd0, 8'(a), 3'd0, $urandom, 1'(p));
    for (int k = 0; k < 4; k++)
      run_model("R10 reg 255", 2'd1, 2'(k), 5'd0, 8'd255, 3'd0, 32'hF00F_0FF0, 1'b1);
  endtask

  task automatic t_direct_sweep();
    for (int d = 0; d < 8; d++)
      for (int a = 0; a <= 40; a += 3)
        run_model((d == 4) ? "R9 R11 direct" : "R11 direct", 2'd2, 2'd0, 5'd0,
                  8'(a), 3'(d), $urandom, 1'(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    req_mode = 2'd0; shift_kind = 2'd0; imm_cnt = 5'd0; reg_cnt = 8'd0;
    direct_op = 3'd0; operand = 32'h0; carry_in = 1'b0;
    t_reset();
    t_latency();
    t_directed();
    t_imm_sweep();
    t_reg_sweep();
    t_direct_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule